// File: doc/BRIEF.md
# Partial Reconfiguration Control Engine

This block sits between a host and the logic that writes a reconfigurable region of the fabric. The host reaches it through a simple 64-bit register port and streams a configuration image into it as 32-bit words, one word per 64-bit write. The engine queues those words in an internal FIFO and hands them to a configuration sink over a valid/ready word stream. The sink reports the end of the operation, and whether it failed, through a done/fault input pair.

Instead of back-pressuring the host, the engine exposes a word credit count in its status register. The host sends a word only while credits remain. A credit comes back each time the sink takes a word. A two-step handshake resets the engine: the host raises a reset request, hardware acknowledges it, and the host then drops the request. An operation opens with a start flag, which captures the target region and image kind. It closes with a push-complete flag. Hardware clears the start flag once the FIFO has drained and the sink has reported done, and the host polls that flag to see completion. Fault causes latch in a write-1-to-clear error register. A 128-bit read-only interface identifier lets software select a compatible image.

The control sequencer has four states. IDLE is entered at power-on reset and by leaving RESET. RESET is entered from any state by a control write with the reset request set, and is left by a control write with it clear. LOAD is entered from IDLE by a control write with start set. DRAIN is entered from LOAD by a control write with push-complete set. DRAIN returns to IDLE when the FIFO is empty while the sink's done input is high.

Top module: `recfg_engine`

## Requirements
- R1: After power-on reset the control register reads 0, the status register reads credits = DEPTH with every other field 0, and the error register reads 0. Offset 0xA8 reads parameter IFID_LO and offset 0xB0 reads IFID_HI. Unmapped offsets and the data register (0x18) read 0.
- R2: A write to control (0x08) with bit 0 = 1 enters RESET from any state. Control then reads bit 0 = 1 and acknowledge bit 4 = 1, and status host field bits 27:24 reads 1. One cycle later the FIFO is flushed, so credits read DEPTH and snk_valid is 0. A later control write with bit 0 = 0 returns to IDLE, where control bits 0 and 4 read 0, host status reads 0 and start reads 0.
- R3: In IDLE, a control write with bit 12 = 1 enters LOAD. Control bit 12 then reads 1 and host status reads 2. Region (control bits 9:8) and image kind (bit 14) are captured onto snk_region/snk_kind and held until start clears, even if the control register is rewritten.
- R4: Status bits 8:0 report credits, equal to DEPTH minus the words queued. An accepted data write takes one credit, a sink handshake returns one, and both in the same cycle leave the count unchanged.
- R5: In LOAD, a write to 0x18 with credits > 0 queues wdata bits 31:0. Bits 63:32 are ignored. Words reach snk_word in the order they were written.
- R6: In LOAD, a control write with bit 13 = 1 enters DRAIN: control bit 13 reads 1 and host status reads 3. The engine stays in DRAIN while the FIFO holds words or snk_done is 0. It then returns to IDLE, and control bits 12 and 13 read 0.
- R7: A data write with no credit sets error bit 0 (overflow). A data write outside LOAD sets error bit 1 (protocol). Neither write is queued.
- R8: snk_err high on the cycle DRAIN completes sets error bit 2. Status bit 16 is the OR of the error bits. Status bits 22:20 read {error bit 2, FIFO full, FIFO not empty}.
- R9: A write to the error register (0x20) clears each bit written as 1. A fault set in the same cycle as its clear stays set.
- R10: The identifier registers ignore writes.
- R11: While snk_valid is high and snk_ready is low (outside RESET), snk_valid and snk_word hold.
- R12: Control bits other than 0, 4, 9:8, 12, 13, 14 and 63:32 read 0. Bits 63:32 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for csr_addr (combinational) |
| snk_valid | output | 1 | Word available to the sink |
| snk_ready | input | 1 | Sink accepts the word |
| snk_word | output | 32 | Configuration word |
| snk_region | output | 2 | Captured target region |
| snk_kind | output | 1 | Captured image kind |
| snk_done | input | 1 | Sink has finished the operation |
| snk_err | input | 1 | Sink reports a failed operation |

## Verification
The credit counter can be charged by a host data write and refunded by a sink handshake in the same cycle. The bench first fills the FIFO, releases one word, and then raises snk_ready on the same clock as a data write. It judges the result by status bits 8:0 staying at 1 and by the extra word arriving after the others in order. A second collision happens when the sink completes with a fault on the very cycle the host clears error bit 2. The bench expects the bit to read 1 afterwards.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DRAIN = 2'd3
    } eng_state_t;

    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_DATA   = 8'h18;
    localparam logic [7:0] OFS_ERROR  = 8'h20;
    localparam logic [7:0] OFS_ID_LO  = 8'hA8;
    localparam logic [7:0] OFS_ID_HI  = 8'hB0;

    localparam int CB_RST   = 0;
    localparam int CB_ACK   = 4;
    localparam int CB_REG_L = 8;
    localparam int CB_START = 12;
    localparam int CB_PUSH  = 13;
    localparam int CB_KIND  = 14;

    localparam int ERR_OVF   = 0;
    localparam int ERR_PROTO = 1;
    localparam int ERR_SINK  = 2;
    localparam int ERR_W     = 3;

    localparam int CREDIT_W = 9;
endpackage

// File: rtl/recfg_fifo.sv
module recfg_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_pop;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign head   = mem[rd_ptr];
    assign do_pop = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CW'(push) - CW'(do_pop);
        end
    end

    // R7: the credit gate upstream must keep pushes off a full queue
    assert_push_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (!full || do_pop));
endmodule

// File: rtl/recfg_credit.sv
module recfg_credit #(
    parameter int DEPTH = 8,
    parameter int CRW   = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           take,
    input  logic           give,
    output logic [CRW-1:0] credits
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credits <= CRW'(DEPTH);
        end else if (flush) begin
            credits <= CRW'(DEPTH);
        end else begin
            credits <= credits - CRW'(take) + CRW'(give);
        end
    end

    assert_credit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        credits <= CRW'(DEPTH));
    assert_no_take_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !flush) |-> (credits != '0));
endmodule

// File: rtl/recfg_fsm.sv
module recfg_fsm
    import recfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_rst,
    input  logic       ctl_start,
    input  logic       ctl_push,
    input  logic [1:0] ctl_region,
    input  logic       ctl_kind,
    input  logic       fifo_empty,
    input  logic       snk_done,
    output eng_state_t state,
    output logic       start_o,
    output logic       push_o,
    output logic       ack_o,
    output logic [3:0] host_code,
    output logic       flush_o,
    output logic       finish_o,
    output logic [1:0] region_o,
    output logic       kind_o
);
    eng_state_t state_nx;
    logic       open_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        open_op  = 1'b0;
        if (ctl_wr && ctl_rst) begin
            state_nx = ST_RESET;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ctl_wr && ctl_start) begin
                        state_nx = ST_LOAD;
                        open_op  = 1'b1;
                    end
                end
                ST_RESET: begin
                    if (ctl_wr) begin
                        state_nx = ST_IDLE;
                    end
                end
                ST_LOAD: begin
                    if (ctl_wr && ctl_push) begin
                        state_nx = ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (fifo_empty && snk_done) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        start_o   = 1'b0;
        push_o    = 1'b0;
        ack_o     = 1'b0;
        flush_o   = 1'b0;
        finish_o  = 1'b0;
        host_code = 4'd0;
        unique case (state)
            ST_IDLE: host_code = 4'd0;
            ST_RESET: begin
                host_code = 4'd1;
                ack_o     = 1'b1;
                flush_o   = 1'b1;
            end
            ST_LOAD: begin
                host_code = 4'd2;
                start_o   = 1'b1;
            end
            ST_DRAIN: begin
                host_code = 4'd3;
                start_o   = 1'b1;
                push_o    = 1'b1;
                finish_o  = fifo_empty && snk_done && !(ctl_wr && ctl_rst);
            end
            default: host_code = 4'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region_o <= '0;
            kind_o   <= 1'b0;
        end else if (open_op) begin
            region_o <= ctl_region;
            kind_o   <= ctl_kind;
        end
    end

    assert_hold_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && $past(start_o)) |-> ($stable(region_o) && $stable(kind_o)));
    assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_o) |-> ($past(fifo_empty && snk_done) || $past(ctl_wr && ctl_rst)));
    assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(ctl_wr && ctl_rst));
endmodule

// File: rtl/recfg_engine.sv
module recfg_engine
    import recfg_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter logic [63:0] IFID_LO = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] IFID_HI = 64'hFEDC_BA98_7654_3210,
    localparam int         CW      = $clog2(DEPTH + 1),
    localparam int         SW      = CREDIT_W + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [7:0]  csr_addr,
    input  logic [63:0] csr_wdata,
    output logic [63:0] csr_rdata,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [31:0] snk_word,
    output logic [1:0]  snk_region,
    output logic        snk_kind,
    input  logic        snk_done,
    input  logic        snk_err
);
    logic                wr_ctl, wr_data, wr_err;
    logic                rst_q, kind_q;
    logic [1:0]          region_q;
    logic [31:0]         cfg_q;
    logic [ERR_W-1:0]    err_q, err_set, err_clr;
    logic [CREDIT_W-1:0] credits;
    logic [CW-1:0]       fifo_cnt;
    logic                fifo_empty, fifo_full;
    logic                accept, pop;
    eng_state_t          state;
    logic                start_b, push_b, ack_b, flush, finish;
    logic [3:0]          host_code;
    logic [63:0]         ctrl_w, status_w;

    assign wr_ctl  = csr_we && (csr_addr == OFS_CTRL);
    assign wr_data = csr_we && (csr_addr == OFS_DATA);
    assign wr_err  = csr_we && (csr_addr == OFS_ERROR);

    assign accept    = wr_data && (state == ST_LOAD) && (credits != '0);
    assign snk_valid = !fifo_empty;
    assign pop       = snk_valid && snk_ready && !flush;

    recfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (wr_ctl),
        .ctl_rst    (csr_wdata[CB_RST]),
        .ctl_start  (csr_wdata[CB_START]),
        .ctl_push   (csr_wdata[CB_PUSH]),
        .ctl_region (csr_wdata[CB_REG_L+1:CB_REG_L]),
        .ctl_kind   (csr_wdata[CB_KIND]),
        .fifo_empty (fifo_empty),
        .snk_done   (snk_done),
        .state      (state),
        .start_o    (start_b),
        .push_o     (push_b),
        .ack_o      (ack_b),
        .host_code  (host_code),
        .flush_o    (flush),
        .finish_o   (finish),
        .region_o   (snk_region),
        .kind_o     (snk_kind)
    );

    recfg_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (accept),
        .push_data (csr_wdata[31:0]),
        .pop       (pop),
        .head      (snk_word),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_cnt)
    );

    recfg_credit #(.DEPTH(DEPTH), .CRW(CREDIT_W)) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .take    (accept),
        .give    (pop),
        .credits (credits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q    <= 1'b0;
            region_q <= '0;
            kind_q   <= 1'b0;
            cfg_q    <= '0;
        end else if (wr_ctl) begin
            rst_q    <= csr_wdata[CB_RST];
            region_q <= csr_wdata[CB_REG_L+1:CB_REG_L];
            kind_q   <= csr_wdata[CB_KIND];
            cfg_q    <= csr_wdata[63:32];
        end
    end

    always_comb begin
        err_set            = '0;
        err_set[ERR_OVF]   = wr_data && (state == ST_LOAD) && (credits == '0);
        err_set[ERR_PROTO] = wr_data && (state != ST_LOAD);
        err_set[ERR_SINK]  = finish && snk_err;
        err_clr            = wr_err ? csr_wdata[ERR_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_q & ~err_clr) | err_set;
        end
    end

    always_comb begin
        ctrl_w                        = '0;
        ctrl_w[CB_RST]                = rst_q;
        ctrl_w[CB_ACK]                = ack_b;
        ctrl_w[CB_REG_L+1:CB_REG_L]   = region_q;
        ctrl_w[CB_START]              = start_b;
        ctrl_w[CB_PUSH]               = push_b;
        ctrl_w[CB_KIND]               = kind_q;
        ctrl_w[63:32]                 = cfg_q;

        status_w                      = '0;
        status_w[CREDIT_W-1:0]        = credits;
        status_w[16]                  = |err_q;
        status_w[22:20]               = {err_q[ERR_SINK], fifo_full, !fifo_empty};
        status_w[27:24]               = host_code;
    end

    always_comb begin
        case (csr_addr)
            OFS_CTRL:   csr_rdata = ctrl_w;
            OFS_STATUS: csr_rdata = status_w;
            OFS_ERROR:  csr_rdata = {{(64-ERR_W){1'b0}}, err_q};
            OFS_ID_LO:  csr_rdata = IFID_LO;
            OFS_ID_HI:  csr_rdata = IFID_HI;
            default:    csr_rdata = '0;
        endcase
    end

    assert_credit_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (SW'(credits) + SW'(fifo_cnt)) == SW'(DEPTH));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(err_q) & ~$past(err_clr) & ~err_q) == '0));
    assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !accept) |=> (err_q[ERR_OVF] || err_q[ERR_PROTO]));
    assert_sink_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready && !flush) |=> (snk_valid && $stable(snk_word)));
endmodule

// File: tb/tb_recfg_engine.sv
`timescale 1ns/100ps
module tb_recfg_engine;
    localparam int          DEPTH = 8;
    localparam logic [63:0] ID_LO = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] ID_HI = 64'hFEDC_BA98_7654_3210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        snk_valid, snk_ready = 1'b0;
    logic [31:0] snk_word;
    logic [1:0]  snk_region;
    logic        snk_kind;
    logic        snk_done = 1'b0, snk_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rx [0:31];
    int rx_n = 0;

    always #2.5 clk = ~clk;

    recfg_engine #(.DEPTH(DEPTH), .IFID_LO(ID_LO), .IFID_HI(ID_HI)) dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .snk_valid(snk_valid),
        .snk_ready(snk_ready), .snk_word(snk_word), .snk_region(snk_region),
        .snk_kind(snk_kind), .snk_done(snk_done), .snk_err(snk_err)
    );

    always @(posedge clk) begin
        if (rst_n && snk_valid && snk_ready && rx_n < 32) begin
            rx[rx_n] <= snk_word;
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        csr_we = 1'b0; csr_addr = a;
        #0.5;
        d = csr_rdata;
    endtask

    function automatic logic [63:0] stat(input int host, input logic [2:0] err,
                                         input bit full, input bit ne, input int cred);
        logic [63:0] s;
        s = '0;
        s[8:0] = 9'(cred);
        s[16] = |err;
        s[22:20] = {err[2], full, ne};
        s[27:24] = 4'(host);
        return s;
    endfunction

    task automatic t_reset_state();
        logic [63:0] v;
        rd(8'h08, v); check("R1 ctrl", v, 64'h0);
        rd(8'h10, v); check("R1 status", v, stat(0, 0, 0, 0, DEPTH));
        rd(8'h20, v); check("R1 error", v, 64'h0);
        rd(8'hA8, v); check("R1 id lo", v, ID_LO);
        rd(8'hB0, v); check("R1 id hi", v, ID_HI);
        rd(8'h18, v); check("R1 data reads 0", v, 64'h0);
        rd(8'h00, v); check("R1 unmapped", v, 64'h0);
    endtask

    task automatic t_idle_drop();
        logic [63:0] v;
        wr(8'h18, 64'h1234_5678);
        rd(8'h20, v); check("R7 protocol bit", v, 64'h2);
        rd(8'h10, v); check("R7 no queue / R8 flag", v, stat(0, 3'b010, 0, 0, DEPTH));
        wr(8'h20, 64'h2);
        rd(8'h20, v); check("R9 w1c", v, 64'h0);
    endtask

    task automatic t_rst_handshake();
        logic [63:0] v;
        wr(8'h08, 64'h1);
        rd(8'h08, v); check("R2 ack", v, 64'h11);
        rd(8'h10, v); check("R2 host reset", v, stat(1, 0, 0, 0, DEPTH));
        wr(8'h08, 64'h0);
        rd(8'h08, v); check("R2 release", v, 64'h0);
        rd(8'h10, v); check("R2 host idle", v, stat(0, 0, 0, 0, DEPTH));
    endtask

    task automatic t_load_stream();
        logic [63:0] v;
        rx_n = 0;
        snk_ready = 1'b0;
        wr(8'h08, 64'h5200);
        rd(8'h08, v); check("R3 start reads", v, 64'h5200);
        rd(8'h10, v); check("R3 host load", v, stat(2, 0, 0, 0, DEPTH));
        check("R3 region", {62'b0, snk_region}, 64'h2);
        check("R3 kind", {63'b0, snk_kind}, 64'h1);
        wr(8'h08, 64'h5100);
        check("R3 region held", {62'b0, snk_region}, 64'h2);
        for (int i = 0; i < 3; i++) wr(8'h18, {32'hFFFF_0000 | 32'(i), 32'hA000_0000 + 32'(i) * 32'h111});
        rd(8'h10, v); check("R4 credits 5", v, stat(2, 0, 0, 1, 5));
        check("R5 head word", {32'b0, snk_word}, 64'hA000_0000);
        for (int i = 3; i < 8; i++) wr(8'h18, {32'hFFFF_0000 | 32'(i), 32'hA000_0000 + 32'(i) * 32'h111});
        rd(8'h10, v); check("R4 credits 0 full", v, stat(2, 0, 1, 1, 0));
        wr(8'h18, 64'h0000_0000_BAD0_BAD0);
        rd(8'h20, v); check("R7 overflow bit", v, 64'h1);
        wr(8'h20, 64'h1);
        @(negedge clk); snk_ready = 1'b1;
        @(negedge clk); snk_ready = 1'b0;
        rd(8'h10, v); check("R4 one credit back", v, stat(2, 0, 0, 1, 1));
        @(negedge clk);
        snk_ready = 1'b1; csr_we = 1'b1; csr_addr = 8'h18; csr_wdata = 64'h5555_5555_A000_0888;
        @(negedge clk);
        csr_we = 1'b0; snk_ready = 1'b0;
        rd(8'h10, v); check("R4 push+pop same cycle", v, stat(2, 0, 0, 1, 1));
        snk_ready = 1'b1;
        repeat (12) @(negedge clk);
        rd(8'h10, v); check("R4 all credits back", v, stat(2, 0, 0, 0, DEPTH));
        check("R5 word count", 64'(rx_n), 64'd9);
        for (int i = 0; i < 9; i++)
            check("R5 order", {32'b0, rx[i]}, {32'b0, 32'hA000_0000 + 32'(i) * 32'h111});
    endtask

    task automatic t_complete_fault();
        logic [63:0] v;
        snk_done = 1'b0;
        wr(8'h08, 64'h7100);
        rd(8'h08, v); check("R6 push flag", v, 64'h7100);
        repeat (4) @(negedge clk);
        rd(8'h10, v); check("R6 waits done", v, stat(3, 0, 0, 0, DEPTH));
        snk_done = 1'b1; snk_err = 1'b1;
        @(negedge clk);
        snk_done = 1'b0; snk_err = 1'b0;
        rd(8'h08, v); check("R6 start cleared", v, 64'h4100);
        rd(8'h10, v); check("R8 sink fault status", v, stat(0, 3'b100, 0, 0, DEPTH));
        rd(8'h20, v); check("R8 sink fault bit", v, 64'h4);
        wr(8'h20, 64'h4);
        rd(8'h20, v); check("R9 cleared", v, 64'h0);
    endtask

    task automatic t_reset_flush();
        logic [63:0] v;
        int keep;
        snk_ready = 1'b0;
        keep = rx_n;
        wr(8'h08, 64'h1000);
        wr(8'h18, 64'h1111);
        wr(8'h18, 64'h2222);
        check("R11 valid held", {63'b0, snk_valid}, 64'h1);
        wr(8'h08, 64'h1);
        @(negedge clk);
        rd(8'h10, v); check("R2 flushed", v, stat(1, 0, 0, 0, DEPTH));
        check("R2 sink idle", {63'b0, snk_valid}, 64'h0);
        wr(8'h08, 64'h0);
        rd(8'h08, v); check("R2 start dropped", v, 64'h0);
        snk_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 nothing delivered", 64'(rx_n), 64'(keep));
    endtask

    task automatic t_clear_collision();
        logic [63:0] v;
        wr(8'h08, 64'h1000);
        wr(8'h08, 64'h3000);
        @(negedge clk);
        snk_done = 1'b1; snk_err = 1'b1;
        csr_we = 1'b1; csr_addr = 8'h20; csr_wdata = 64'h4;
        @(negedge clk);
        csr_we = 1'b0; snk_done = 1'b0; snk_err = 1'b0;
        rd(8'h20, v); check("R9 set wins", v, 64'h4);
        wr(8'h20, 64'h4);
        rd(8'h20, v); check("R9 cleared after", v, 64'h0);
    endtask

    task automatic t_fields();
        logic [63:0] v;
        wr(8'h08, 64'hDEAD_BEEF_0000_8EE0);
        rd(8'h08, v); check("R12 reserved zero", v, 64'hDEAD_BEEF_0000_0200);
        wr(8'h08, 64'h0);
        wr(8'hA8, 64'h0);
        wr(8'hB0, 64'h0);
        rd(8'hA8, v); check("R10 id lo kept", v, ID_LO);
        rd(8'hB0, v); check("R10 id hi kept", v, ID_HI);
        wr(8'h30, 64'hFFFF);
        rd(8'h30, v); check("R12 unmapped", v, 64'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_idle_drop();
        t_rst_handshake();
        t_load_stream();
        t_complete_fault();
        t_reset_flush();
        t_clear_collision();
        t_fields();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule